// File: doc/BRIEF.md
# Write-Through Store Buffer

This block sits between a write-through data cache and the slower memory below it. Each store the cache pushes down is queued in a small circular buffer. The store side therefore waits only when every slot is taken. Queued stores leave one at a time, oldest first, through a single-word valid/ready port toward lower memory.

Two checks keep the queue coherent with reads and keep it compact. Any read address presented by the cache is compared with every live slot. On a match, the newest matching word is returned from the buffer, so memory is never asked for data that is still in flight. A store whose address is already queued in a slot that is not currently being offered to memory is folded into that slot, byte by byte. The slot at the head of the queue is being offered to memory and is locked, so a store matching it takes a fresh slot. An empty indication lets a controller drain the queue completely before sending a read miss downward.

Addresses are compared as whole words: all address bits must be equal. The depth must be a power of two.

Top module: `wt_store_buffer`

## Requirements
- R1: After reset, `empty` is 1, `mem_valid` is 0, `st_ready` is 1 and `rd_hit` is 0.
- R2: `st_ready` is 0 only when all DEPTH slots are occupied and the presented store cannot be merged. While it is 0 the store is held off and nothing is queued.
- R3: With memory not accepting, DEPTH stores to distinct addresses are accepted on consecutive cycles without a wait.
- R4: Queued stores appear on the memory port in arrival order. `mem_valid` stays high with stable address, data and mask until `mem_ready`. A slot is freed on the handshake cycle.
- R5: `rd_hit` and `rd_data`/`rd_mask` depend combinationally on `rd_addr` and the slots held at the start of the cycle. When several slots match, the newest one is returned. With no match, `rd_hit`, `rd_data` and `rd_mask` are 0.
- R6: A store whose address matches a queued slot other than the head is accepted even when the buffer is full and does not take a new slot. Mask bit i selects byte i, which is data bits 8i+7 down to 8i. Bytes whose mask bit is 1 are replaced, and the slot mask becomes the OR of the old and new masks.
- R7: The head slot, while `mem_valid` is high, is never merged into. A store matching only the head takes a new slot, or stalls when none is free. Both words then reach memory in order.
- R8: `empty` is 1 exactly when no slot is occupied, and `mem_valid` is 0 whenever `empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request from the cache |
| st_ready | output | 1 | Store accepted this cycle (0 = stall) |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_mask | input | DW/8 | Store byte enables |
| rd_addr | input | AW | Read address to look up |
| rd_hit | output | 1 | A live slot holds rd_addr |
| rd_data | output | DW | Newest matching data word |
| rd_mask | output | DW/8 | Valid bytes of rd_data |
| mem_valid | output | 1 | Write offered to lower memory |
| mem_ready | input | 1 | Lower memory accepts the write |
| mem_addr | output | AW | Write address |
| mem_data | output | DW | Write data |
| mem_mask | output | DW/8 | Write byte enables |
| empty | output | 1 | No slot is occupied |

## Verification
The hardest case to reach is a store that matches the slot currently being offered to memory while a younger copy of the same address is also queued. In that case the lock, the newest-match selection and a later merge into the younger copy all act together. The stimulus holds `mem_ready` low, queues the same address twice, reads it back, and merges a partial store into the second copy. It then fills the rest of the buffer so that a stall shows that no extra slot was taken. The buffer is also driven full with memory stalled, which shows a merge accepted while full and a head-matching store refused. The scoreboard checks every drained word against a queue model.

// File: rtl/wtb_pkg.sv
package wtb_pkg;
  localparam int unsigned WTB_DEPTH = 4;
  localparam int unsigned WTB_AW    = 32;
  localparam int unsigned WTB_DW    = 32;

  typedef enum logic [1:0] {
    WR_IDLE  = 2'd0,
    WR_ALLOC = 2'd1,
    WR_MERGE = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/wtb_match.sv
// Per-slot address comparator, qualified by slot liveness.
module wtb_match #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int PTR_W = 2,
  parameter int CNT_W = 3
) (
  input  logic [DEPTH-1:0][AW-1:0] ent_addr,
  input  logic [PTR_W-1:0]         head,
  input  logic [CNT_W-1:0]         count,
  input  logic [AW-1:0]            key,
  output logic [DEPTH-1:0]         hit
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic [PTR_W-1:0] age;
    logic             live;
    assign age    = PTR_W'(i) - head;
    assign live   = CNT_W'(age) < count;
    assign hit[i] = live && (ent_addr[i] == key);
  end
endmodule

// File: rtl/wtb_pick.sv
// Selects the newest hit, scanning backwards from the tail pointer.
module wtb_pick #(
  parameter int DEPTH = 4,
  parameter int PTR_W = 2
) (
  input  logic [DEPTH-1:0] hit,
  input  logic [PTR_W-1:0] tail,
  output logic             found,
  output logic [PTR_W-1:0] idx
);
  always_comb begin
    logic [PTR_W-1:0] pos;
    found = 1'b0;
    idx   = '0;
    for (int k = DEPTH; k >= 1; k--) begin
      pos = tail - PTR_W'(k);
      if (hit[pos]) begin
        found = 1'b1;
        idx   = pos;
      end
    end
  end
endmodule

// File: rtl/wtb_merge.sv
// Byte-wise combine of a new store into a queued word.
module wtb_merge #(
  parameter int DW = 32,
  localparam int MW = DW / 8
) (
  input  logic [DW-1:0] old_data,
  input  logic [MW-1:0] old_mask,
  input  logic [DW-1:0] new_data,
  input  logic [MW-1:0] new_mask,
  output logic [DW-1:0] out_data,
  output logic [MW-1:0] out_mask
);
  for (genvar b = 0; b < MW; b++) begin : g_byte
    assign out_data[8*b +: 8] = new_mask[b] ? new_data[8*b +: 8] : old_data[8*b +: 8];
  end
  assign out_mask = old_mask | new_mask;
endmodule

// File: rtl/wt_store_buffer.sv
module wt_store_buffer
  import wtb_pkg::*;
#(
  parameter int DEPTH = WTB_DEPTH,
  parameter int AW    = WTB_AW,
  parameter int DW    = WTB_DW,
  localparam int MW    = DW / 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [MW-1:0] st_mask,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_hit,
  output logic [DW-1:0] rd_data,
  output logic [MW-1:0] rd_mask,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic [MW-1:0] mem_mask,
  output logic          empty
);
  // Slot storage (no reset: liveness comes from the pointers).
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;
  logic [DEPTH-1:0][MW-1:0] mask_q;

  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] count_q, count_d;

  logic [DEPTH-1:0] rd_hits, st_hits_raw, st_hits, head_onehot;
  logic             rd_found, merge_found;
  logic [PTR_W-1:0] rd_idx, merge_idx;
  logic [DW-1:0]    mg_data;
  logic [MW-1:0]    mg_mask;
  logic             full, pop, alloc;
  wr_kind_e         wr_kind;

  // Read-after-write lookup
  wtb_match #(.DEPTH(DEPTH), .AW(AW), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_rd_match (
    .ent_addr(addr_q), .head(head_q), .count(count_q), .key(rd_addr), .hit(rd_hits)
  );
  wtb_pick #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_rd_pick (
    .hit(rd_hits), .tail(tail_q), .found(rd_found), .idx(rd_idx)
  );

  // Merge lookup; the head slot is locked while it is offered to memory
  wtb_match #(.DEPTH(DEPTH), .AW(AW), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_st_match (
    .ent_addr(addr_q), .head(head_q), .count(count_q), .key(st_addr), .hit(st_hits_raw)
  );
  assign head_onehot = DEPTH'(1) << head_q;
  assign st_hits     = st_hits_raw & ~head_onehot;
  wtb_pick #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_st_pick (
    .hit(st_hits), .tail(tail_q), .found(merge_found), .idx(merge_idx)
  );

  wtb_merge #(.DW(DW)) u_merge (
    .old_data(data_q[merge_idx]), .old_mask(mask_q[merge_idx]),
    .new_data(st_data), .new_mask(st_mask),
    .out_data(mg_data), .out_mask(mg_mask)
  );

  // Control
  assign full      = (count_q == CNT_W'(DEPTH));
  assign empty     = (count_q == '0);
  assign mem_valid = !empty;
  assign st_ready  = merge_found || !full;
  assign pop       = mem_valid && mem_ready;

  always_comb begin
    wr_kind = WR_IDLE;
    if (st_valid && merge_found)  wr_kind = WR_MERGE;
    else if (st_valid && !full)   wr_kind = WR_ALLOC;
  end
  assign alloc = (wr_kind == WR_ALLOC);

  // Next state
  always_comb begin
    head_d  = head_q;
    tail_d  = tail_q;
    count_d = count_q;
    if (pop)   head_d = head_q + PTR_W'(1);
    if (alloc) tail_d = tail_q + PTR_W'(1);
    case ({alloc, pop})
      2'b10:   count_d = count_q + CNT_W'(1);
      2'b01:   count_d = count_q - CNT_W'(1);
      default: count_d = count_q;
    endcase
  end

  // Pointer registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  // Slot registers with explicit write enables
  always_ff @(posedge clk) begin
    case (wr_kind)
      WR_ALLOC: begin
        addr_q[tail_q] <= st_addr;
        data_q[tail_q] <= st_data;
        mask_q[tail_q] <= st_mask;
      end
      WR_MERGE: begin
        data_q[merge_idx] <= mg_data;
        mask_q[merge_idx] <= mg_mask;
      end
      default: ;
    endcase
  end

  // Outputs
  assign rd_hit   = rd_found;
  assign rd_data  = rd_found  ? data_q[rd_idx] : '0;
  assign rd_mask  = rd_found  ? mask_q[rd_idx] : '0;
  assign mem_addr = mem_valid ? addr_q[head_q] : '0;
  assign mem_data = mem_valid ? data_q[head_q] : '0;
  assign mem_mask = mem_valid ? mask_q[head_q] : '0;
endmodule

// File: rtl/wtb_checker.sv
module wtb_checker #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int MW    = DW / 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             st_valid,
  input logic             st_ready,
  input logic             mem_valid,
  input logic             mem_ready,
  input logic [AW-1:0]    mem_addr,
  input logic [DW-1:0]    mem_data,
  input logic [MW-1:0]    mem_mask,
  input logic             rd_hit,
  input logic             empty,
  input logic [CNT_W-1:0] count_q
);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  a_r2_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ready |-> count_q == CNT_W'(DEPTH));

  a_r4_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_mask));

  a_r8_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !mem_valid);

  a_r5_hit_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> !empty);

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + CNT_W'(1)) ||
             (count_q + CNT_W'(1) == $past(count_q)));

  a_r2_stall_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> count_q <= $past(count_q));
endmodule

bind wt_store_buffer wtb_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_data(mem_data), .mem_mask(mem_mask), .rd_hit(rd_hit),
  .empty(empty), .count_q(count_q)
);

// File: tb/wt_store_buffer_tb.sv
module wt_store_buffer_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        st_valid;
  logic        st_ready;
  logic [31:0] st_addr, st_data;
  logic [3:0]  st_mask;
  logic [31:0] rd_addr;
  logic        rd_hit;
  logic [31:0] rd_data;
  logic [3:0]  rd_mask;
  logic        mem_valid, mem_ready;
  logic [31:0] mem_addr, mem_data;
  logic [3:0]  mem_mask;
  logic        empty;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    logic [3:0]  m;
  } ent_t;
  ent_t model[$];

  always #(PERIOD/2) clk = ~clk;

  wt_store_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_mask(st_mask),
    .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_data(rd_data), .rd_mask(rd_mask),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_mask(mem_mask), .empty(empty)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected-queue update when a store is accepted (head slot 0 is locked).
  function automatic void model_accept(input logic [31:0] a, d, input logic [3:0] m);
    for (int i = model.size() - 1; i >= 1; i--) begin
      if (model[i].a == a) begin
        for (int b = 0; b < 4; b++)
          if (m[b]) model[i].d[8*b +: 8] = d[8*b +: 8];
        model[i].m = model[i].m | m;
        return;
      end
    end
    model.push_back('{a: a, d: d, m: m});
  endfunction

  // Monitor: pops the scoreboard on every memory handshake (R4 ordering).
  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      if (model.size() == 0) begin
        chk(1'b0, "R4 unexpected write", {32'b0, mem_addr}, 64'b0);
      end else begin
        chk(mem_addr == model[0].a && mem_data == model[0].d && mem_mask == model[0].m,
            "R4 drain order/content", {mem_addr, mem_data}, {model[0].a, model[0].d});
        void'(model.pop_front());
      end
    end
  end

  // Driver: called at a falling edge, returns at a falling edge.
  task automatic do_store(input logic [31:0] a, d, input logic [3:0] m, output int waits);
    bit taken = 0;
    waits = 0;
    st_valid = 1'b1; st_addr = a; st_data = d; st_mask = m;
    while (!taken) begin
      #1;
      if (st_ready) begin
        model_accept(a, d, m);
        taken = 1;
      end else begin
        waits++;
      end
      @(posedge clk); @(negedge clk);
    end
    st_valid = 1'b0;
  endtask

  task automatic probe_read(input logic [31:0] a, input bit eh, input logic [31:0] ed,
                            input logic [3:0] em, input string tag);
    rd_addr = a;
    #1;
    chk(rd_hit == eh, tag, {63'b0, rd_hit}, {63'b0, eh});
    chk(rd_data == ed && rd_mask == em, tag, {28'b0, rd_mask, rd_data}, {28'b0, em, ed});
  endtask

  task automatic probe_stall(input logic [31:0] a, input string tag);
    st_valid = 1'b1; st_addr = a; st_data = 32'hDEAD0000; st_mask = 4'hF;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk(st_ready == 1'b0, tag, {63'b0, st_ready}, 64'b0);
      @(posedge clk); @(negedge clk);
    end
    st_valid = 1'b0;
  endtask

  task automatic wait_empty();
    for (int c = 0; c < 100 && !empty; c++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int w;
    rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0; st_mask = '0;
    rd_addr = 32'h0; mem_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R8 reset state
    #1;
    chk(empty == 1'b1,     "R1 empty",     {63'b0, empty},     64'd1);
    chk(mem_valid == 1'b0, "R1 mem_valid", {63'b0, mem_valid}, 64'd0);
    chk(st_ready == 1'b1,  "R1 st_ready",  {63'b0, st_ready},  64'd1);
    chk(rd_hit == 1'b0,    "R1 rd_hit",    {63'b0, rd_hit},    64'd0);

    // R3 burst of four distinct stores, memory stalled
    do_store(32'h100, 32'h11111111, 4'hF, w); chk(w == 0, "R3 burst 0", w, 0);
    do_store(32'h104, 32'h22222222, 4'hF, w); chk(w == 0, "R3 burst 1", w, 0);
    do_store(32'h108, 32'hAABBCCDD, 4'hC, w); chk(w == 0, "R3 burst 2", w, 0);
    do_store(32'h10C, 32'h44444444, 4'hF, w); chk(w == 0, "R3 burst 3", w, 0);
    #1;
    chk(empty == 1'b0, "R8 not empty", {63'b0, empty}, 64'd0);
    chk(mem_valid && mem_addr == 32'h100, "R4 head offered", {32'b0, mem_addr}, 64'h100);

    // R2 full stall on new address
    probe_stall(32'h200, "R2 full stall");

    // R5 forwarding while full
    probe_read(32'h104, 1'b1, 32'h22222222, 4'hF, "R5 forward hit");
    probe_read(32'h300, 1'b0, 32'h0, 4'h0, "R5 miss zero");

    // R6 merge into non-head slot while full
    do_store(32'h108, 32'h00001122, 4'h3, w);
    chk(w == 0, "R6 merge accepted while full", w, 0);
    probe_read(32'h108, 1'b1, 32'hAABB1122, 4'hF, "R6 merged bytes");
    probe_stall(32'h204, "R6 merge took no slot");

    // R7 head slot locked: matching store must stall while full
    probe_stall(32'h100, "R7 head locked stall");

    // Release memory: head-matching store allocates new slot, all drain in order
    mem_ready = 1'b1;
    do_store(32'h100, 32'h55555555, 4'hF, w);
    wait_empty();
    #1;
    chk(empty == 1'b1 && model.size() == 0, "R8 drained", {63'b0, empty}, 64'd1);
    probe_read(32'h100, 1'b0, 32'h0, 4'h0, "R8 no hit after drain");

    // R7/R5 same address twice with head locked; newest wins
    mem_ready = 1'b0;
    do_store(32'h400, 32'h00000001, 4'hF, w);
    do_store(32'h400, 32'h00000002, 4'hF, w);
    probe_read(32'h400, 1'b1, 32'h00000002, 4'hF, "R5 newest match");
    chk(mem_data == 32'h1, "R7 head kept old word", {32'b0, mem_data}, 64'h1);
    do_store(32'h400, 32'h00000033, 4'h1, w);
    probe_read(32'h400, 1'b1, 32'h00000033, 4'hF, "R6 merge into younger copy");
    do_store(32'h500, 32'h00000005, 4'h1, w); chk(w == 0, "R3 slot 3 free", w, 0);
    do_store(32'h504, 32'h00000006, 4'h2, w); chk(w == 0, "R3 slot 4 free", w, 0);
    probe_stall(32'h508, "R2 full after partial merge");

    // R4 drain with memory toggling
    for (int c = 0; c < 16; c++) begin
      mem_ready = c[0];
      @(posedge clk); @(negedge clk);
    end
    mem_ready = 1'b1;
    wait_empty();

    // R4 streaming with store and drain in the same cycles
    for (int k = 0; k < 10; k++) begin
      do_store(32'h800 + 32'(k * 4), 32'hC0DE0000 + 32'(k), 4'hF, w);
      chk(w == 0, "R2 no stall while streaming", w, 0);
    end
    wait_empty();
    #1;
    chk(empty == 1'b1 && model.size() == 0, "R4 all writes seen", {32'b0, 32'(model.size())}, 64'd0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule